// File: doc/BRIEF.md
# Paged Address Translation Map

This block turns a 24-bit address into an address in on-board RAM through a writable table of 1024 map slots. Each slot is 16 bits wide. The low ten address bits pass straight through as the byte offset within a 1024-byte page. The next ten bits pick a slot. The top nibble plays no part. The chosen slot supplies a physical frame number, a flag that routes the access to memory on the expansion connector instead of on-board memory, and a flag that reverses the byte order of the access.

A single lookup port serves both the network controller and the host, because both see memory through the same map. An access is either a 16-bit word or a single byte. When the byte-order flag is set, a word has its two bytes exchanged in both directions. A byte access keeps its data but has its lane select inverted. A separate 16-bit register port lets the host write any slot and read it back. Slots may alias one another. In particular, the last slot, which covers the top of the address space, can point at frame 0 so that a structure the controller expects near the top of its space lands in the first RAM page.

Top module: `page_xlate_map`

## Requirements
- R1: Request address bits 19:10 select the map slot and bits 9:0 are the page offset. Bits 23:20 have no effect on any response output.
- R2: `rspPhysAddr` equals {slot entry bits 7:0, page offset}. Entry bits 14 and 12 have no effect on translation.
- R3: A host write of `mapWrData` to slot `mapSlot` is stored in full. A read of that slot (`mapRdEn`) returns those 16 bits on `mapRdData`, with `mapRdValid` high for exactly the cycle after the read request.
- R4: A lookup takes one cycle. `rspValid` is high in the cycle after `reqValid` and low in the cycle after a cycle without a request.
- R5: For a word access (`reqWide`=1), both lane enables are set (`rspLaneEn`=2'b11). When entry bit 15 is set, the bytes of `rspWrData` are exchanged relative to `reqWrData`, and the bytes of `rspRdData` are exchanged relative to `memRdData`. When bit 15 is clear, both pass unchanged.
- R6: For a byte access (`reqWide`=0), the lane is upper when `reqHiByte` XOR entry bit 15 is 1 (`rspLaneEn`=2'b10) and lower otherwise (2'b01). The write byte `reqWrData[7:0]` appears on both lanes of `rspWrData`. `rspRdData` holds the selected lane of `memRdData` in bits 7:0, with zero above.
- R7: `rspExpansion` equals entry bit 13 (1 = expansion connector memory, 0 = on-board memory).
- R8: `rspOutOfRange` is 1 when entry bit 13 is 0 and entry bits 11:8 are not all zero. When it is 1, `rspLaneEn` is 2'b00. With bit 13 set, the flag is never raised.
- R9: Several slots may hold the same frame. Slot 1023 aliased to frame 0 maps address 0xFFFFF4 to physical address 0x003F4.
- R10: When a host write and a lookup or readback of the same slot happen in the same cycle, the lookup and readback see the previous contents. The new contents take effect from the next request.
- R11: During and right after reset, `rspValid`, `mapRdValid` and `rspLaneEn` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapWrEn | input | 1 | Host writes slot `mapSlot` |
| mapRdEn | input | 1 | Host reads slot `mapSlot` |
| mapSlot | input | 10 | Slot index for the host register port |
| mapWrData | input | 16 | Entry value to store |
| mapRdData | output | 16 | Entry value read back |
| mapRdValid | output | 1 | `mapRdData` is valid this cycle |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 24 | Address to translate |
| reqWide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| reqHiByte | input | 1 | Byte access targets the upper lane |
| reqWrData | input | 16 | Write data from the requester |
| rspValid | output | 1 | Translation result is valid |
| rspPhysAddr | output | 18 | Physical RAM address |
| rspExpansion | output | 1 | Access goes to expansion connector memory |
| rspOutOfRange | output | 1 | On-board frame number exceeds 255 |
| rspLaneEn | output | 2 | Byte lane enables toward memory |
| rspWrData | output | 16 | Write data after lane handling |
| memRdData | input | 16 | Data read from memory for the current response |
| rspRdData | output | 16 | Read data returned to the requester |

## Verification
The hardest case to reach from the ports is a host write and a lookup plus readback of the same slot landing on the same clock edge. Only that case shows whether the table reads before it writes. The bench lines up all three requests in one cycle on a slot whose old and new entries differ in frame, order flag and memory select. It checks the old response, then issues the lookup again and expects the new one. The bench also writes every slot with two arithmetic patterns and sweeps all 1024 slots through word and byte accesses, with varying top nibbles. This covers every combination of order flag, memory select and frame high bits.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

  // Strobes the control half hands to the storage and datapath halves.
  typedef struct packed {
    logic tblWr;   // host stores an entry
    logic tblRd;   // host reads an entry back
    logic look;    // translation request accepted
    logic wide;    // 16-bit access
    logic hiByte;  // byte access names the upper lane
  } xlStrobe_t;

endpackage

// File: rtl/page_xlate_ctrl.sv
module page_xlate_ctrl
  import page_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mapWrEn,
  input  logic      mapRdEn,
  input  logic      reqValid,
  input  logic      reqWide,
  input  logic      reqHiByte,
  output xlStrobe_t strb,
  output logic      rspValid,
  output logic      mapRdValid
);

  always_comb begin
    strb.tblWr  = mapWrEn;
    strb.tblRd  = mapRdEn;
    strb.look   = reqValid;
    strb.wide   = reqWide;
    strb.hiByte = reqHiByte & ~reqWide;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      mapRdValid <= 1'b0;
    end else begin
      rspValid   <= strb.look;
      mapRdValid <= strb.tblRd;
    end
  end

  // R4
  lookup_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R4
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R3
  readback_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    mapRdEn |=> mapRdValid);

endmodule

// File: rtl/page_xlate_table.sv
module page_xlate_table
  import page_xlate_pkg::*;
#(
  parameter int SLOT_W  = 10,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlStrobe_t          strb,
  input  logic [SLOT_W-1:0]  hostSlot,
  input  logic [ENTRY_W-1:0] hostWrData,
  input  logic [SLOT_W-1:0]  lookSlot,
  output logic [ENTRY_W-1:0] hostRdData,
  output logic [ENTRY_W-1:0] lookEntry
);

  localparam int NUM_SLOTS = 1 << SLOT_W;

  logic [ENTRY_W-1:0] mapMem [NUM_SLOTS];

  // Storage has no reset; the host programs every slot before use.
  always_ff @(posedge clk) begin
    if (strb.tblWr) mapMem[hostSlot] <= hostWrData;
  end

  // Both read ports sample the old contents on a colliding write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData <= '0;
      lookEntry  <= '0;
    end else begin
      if (strb.tblRd) hostRdData <= mapMem[hostSlot];
      if (strb.look)  lookEntry  <= mapMem[lookSlot];
    end
  end

  // R3
  slot_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tblWr |=> mapMem[$past(hostSlot)] == $past(hostWrData));
  // R10
  read_before_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.look && strb.tblWr && lookSlot == hostSlot)
      |=> lookEntry == $past(mapMem[lookSlot]));

endmodule

// File: rtl/page_xlate_dp.sv
module page_xlate_dp
  import page_xlate_pkg::*;
#(
  parameter int OFF_W     = 10,
  parameter int FRAME_W   = 8,
  parameter int PFN_W     = 12,
  parameter int ENTRY_W   = 16,
  parameter int DATA_W    = 16,
  parameter int ORDER_BIT = 15,
  parameter int BUS_BIT   = 13,
  localparam int PHYS_W   = FRAME_W + OFF_W,
  localparam int LANE_W   = DATA_W / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlStrobe_t          strb,
  input  logic [OFF_W-1:0]   reqOffset,
  input  logic [DATA_W-1:0]  reqWrData,
  input  logic [ENTRY_W-1:0] lookEntry,
  input  logic [DATA_W-1:0]  memRdData,
  output logic [PHYS_W-1:0]  rspPhysAddr,
  output logic               rspExpansion,
  output logic               rspOutOfRange,
  output logic [1:0]         rspLaneEn,
  output logic [DATA_W-1:0]  rspWrData,
  output logic [DATA_W-1:0]  rspRdData
);

  logic [OFF_W-1:0]  offQ;
  logic              wideQ;
  logic              hiQ;
  logic              liveQ;
  logic [DATA_W-1:0] wrDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ    <= '0;
      wideQ   <= 1'b0;
      hiQ     <= 1'b0;
      liveQ   <= 1'b0;
      wrDataQ <= '0;
    end else if (strb.look) begin
      offQ    <= reqOffset;
      wideQ   <= strb.wide;
      hiQ     <= strb.hiByte;
      liveQ   <= 1'b1;
      wrDataQ <= reqWrData;
    end
  end

  logic             swapOn;
  logic             onExp;
  logic [PFN_W-1:0] pfn;
  logic             pfnHigh;
  logic             effHi;
  logic             unusedEntry;

  assign swapOn      = lookEntry[ORDER_BIT];
  assign onExp       = lookEntry[BUS_BIT];
  assign pfn         = lookEntry[PFN_W-1:0];
  assign pfnHigh     = |pfn[PFN_W-1:FRAME_W];
  assign effHi       = hiQ ^ swapOn;
  assign unusedEntry = ^lookEntry;

  function automatic logic [DATA_W-1:0] laneSwap(input logic [DATA_W-1:0] d);
    return {d[LANE_W-1:0], d[DATA_W-1:LANE_W]};
  endfunction

  always_comb begin
    rspPhysAddr   = {pfn[FRAME_W-1:0], offQ};
    rspExpansion  = onExp;
    rspOutOfRange = ~onExp & pfnHigh;

    if (!liveQ || rspOutOfRange) rspLaneEn = 2'b00;
    else if (wideQ)              rspLaneEn = 2'b11;
    else if (effHi)              rspLaneEn = 2'b10;
    else                         rspLaneEn = 2'b01;

    if (wideQ) begin
      rspWrData = swapOn ? laneSwap(wrDataQ) : wrDataQ;
      rspRdData = swapOn ? laneSwap(memRdData) : memRdData;
    end else begin
      rspWrData = {wrDataQ[LANE_W-1:0], wrDataQ[LANE_W-1:0]};
      rspRdData = {{LANE_W{1'b0}},
                   effHi ? memRdData[DATA_W-1:LANE_W] : memRdData[LANE_W-1:0]};
    end
  end

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.look |=> rspPhysAddr[OFF_W-1:0] == $past(reqOffset));
  // R6
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.look && !strb.wide) |=> $countones(rspLaneEn) <= 1);
  // R5
  word_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.look && strb.wide) |=> (rspLaneEn == 2'b11 || rspLaneEn == 2'b00));
  // R5
  word_bits_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.look && strb.wide) |=> $countones(rspWrData) == $countones($past(reqWrData)));

endmodule

// File: rtl/page_xlate_map.sv
module page_xlate_map
  import page_xlate_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SLOT_W    = 10,
  parameter int OFF_W     = 10,
  parameter int FRAME_W   = 8,
  parameter int PFN_W     = 12,
  parameter int ENTRY_W   = 16,
  parameter int DATA_W    = 16,
  parameter int ORDER_BIT = 15,
  parameter int BUS_BIT   = 13,
  localparam int PHYS_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mapWrEn,
  input  logic               mapRdEn,
  input  logic [SLOT_W-1:0]  mapSlot,
  input  logic [ENTRY_W-1:0] mapWrData,
  output logic [ENTRY_W-1:0] mapRdData,
  output logic               mapRdValid,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWide,
  input  logic               reqHiByte,
  input  logic [DATA_W-1:0]  reqWrData,
  output logic               rspValid,
  output logic [PHYS_W-1:0]  rspPhysAddr,
  output logic               rspExpansion,
  output logic               rspOutOfRange,
  output logic [1:0]         rspLaneEn,
  output logic [DATA_W-1:0]  rspWrData,
  input  logic [DATA_W-1:0]  memRdData,
  output logic [DATA_W-1:0]  rspRdData
);

  xlStrobe_t         strb;
  logic [SLOT_W-1:0] lookSlot;
  logic [OFF_W-1:0]  lookOff;
  logic [ENTRY_W-1:0] lookEntry;
  logic              unusedTopBits;

  assign lookSlot      = reqAddr[OFF_W +: SLOT_W];
  assign lookOff       = reqAddr[OFF_W-1:0];
  assign unusedTopBits = ^reqAddr[ADDR_W-1:OFF_W+SLOT_W];

  page_xlate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mapWrEn   (mapWrEn),
    .mapRdEn   (mapRdEn),
    .reqValid  (reqValid),
    .reqWide   (reqWide),
    .reqHiByte (reqHiByte),
    .strb      (strb),
    .rspValid  (rspValid),
    .mapRdValid(mapRdValid)
  );

  page_xlate_table #(
    .SLOT_W (SLOT_W),
    .ENTRY_W(ENTRY_W)
  ) u_table (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hostSlot  (mapSlot),
    .hostWrData(mapWrData),
    .lookSlot  (lookSlot),
    .hostRdData(mapRdData),
    .lookEntry (lookEntry)
  );

  page_xlate_dp #(
    .OFF_W    (OFF_W),
    .FRAME_W  (FRAME_W),
    .PFN_W    (PFN_W),
    .ENTRY_W  (ENTRY_W),
    .DATA_W   (DATA_W),
    .ORDER_BIT(ORDER_BIT),
    .BUS_BIT  (BUS_BIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqOffset    (lookOff),
    .reqWrData    (reqWrData),
    .lookEntry    (lookEntry),
    .memRdData    (memRdData),
    .rspPhysAddr  (rspPhysAddr),
    .rspExpansion (rspExpansion),
    .rspOutOfRange(rspOutOfRange),
    .rspLaneEn    (rspLaneEn),
    .rspWrData    (rspWrData),
    .rspRdData    (rspRdData)
  );

  // R8
  oor_blocks_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspOutOfRange |-> rspLaneEn == 2'b00);

endmodule

// File: tb/page_xlate_map_tb.sv
module page_xlate_map_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mapWrEn = 1'b0, mapRdEn = 1'b0;
  logic [9:0]  mapSlot = '0;
  logic [15:0] mapWrData = '0;
  logic [15:0] mapRdData;
  logic        mapRdValid;
  logic        reqValid = 1'b0;
  logic [23:0] reqAddr = '0;
  logic        reqWide = 1'b0, reqHiByte = 1'b0;
  logic [15:0] reqWrData = '0;
  logic        rspValid;
  logic [17:0] rspPhysAddr;
  logic        rspExpansion, rspOutOfRange;
  logic [1:0]  rspLaneEn;
  logic [15:0] rspWrData, memRdData = '0, rspRdData;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [15:0] model [1024];

  always #5 clk = ~clk;

  page_xlate_map u_dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int s, input bit inv);
    logic [15:0] v;
    v = 16'(s * 1717 + 467);
    return inv ? ~v : v;
  endfunction

  task automatic hostWrite(input int s, input logic [15:0] v);
    mapWrEn = 1'b1; mapSlot = 10'(s); mapWrData = v;
    @(negedge clk);
    mapWrEn = 1'b0;
    model[s] = v;
  endtask

  task automatic hostRead(input int s);
    mapRdEn = 1'b1; mapSlot = 10'(s);
    @(negedge clk);
    mapRdEn = 1'b0;
    chk("R3", "valid", 32'(mapRdValid), 32'd1);
    chk("R3", "rdata", 32'(mapRdData), 32'(model[s]));
  endtask

  // Expected response for a request against entry e.
  task automatic expectRsp(input string tag, input logic [15:0] e, input logic [23:0] a,
                           input logic w, input logic hi, input logic [15:0] wd,
                           input logic [15:0] mrd);
    logic swp, ex, oor, eh;
    logic [1:0] ln;
    logic [15:0] ewd, erd;
    swp = e[15]; ex = e[13];
    oor = !ex && (e[11:8] != 4'h0);
    eh  = hi ^ swp;
    if (oor) ln = 2'b00; else if (w) ln = 2'b11; else ln = eh ? 2'b10 : 2'b01;
    if (w) begin
      ewd = swp ? {wd[7:0], wd[15:8]} : wd;
      erd = swp ? {mrd[7:0], mrd[15:8]} : mrd;
    end else begin
      ewd = {wd[7:0], wd[7:0]};
      erd = {8'h00, eh ? mrd[15:8] : mrd[7:0]};
    end
    chk("R4", "rspValid", 32'(rspValid), 32'd1);
    chk(tag, "phys", 32'(rspPhysAddr), 32'({e[7:0], a[9:0]}));
    chk("R7", "expansion", 32'(rspExpansion), 32'(ex));
    chk("R8", "outOfRange", 32'(rspOutOfRange), 32'(oor));
    chk(w ? "R5" : "R6", "laneEn", 32'(rspLaneEn), 32'(ln));
    chk(w ? "R5" : "R6", "wrData", 32'(rspWrData), 32'(ewd));
    chk(w ? "R5" : "R6", "rdData", 32'(rspRdData), 32'(erd));
  endtask

  task automatic lookup(input string tag, input logic [23:0] a, input logic w,
                        input logic hi, input logic [15:0] wd, input logic [15:0] mrd);
    logic [15:0] e;
    e = model[a[19:10]];
    reqValid = 1'b1; reqAddr = a; reqWide = w; reqHiByte = hi; reqWrData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    memRdData = mrd;
    #1;
    expectRsp(tag, e, a, w, hi, wd, mrd);
  endtask

  task automatic sweep(input bit inv);
    for (int s = 0; s < 1024; s++) hostWrite(s, pat(s, inv));
    for (int s = 0; s < 1024; s++) hostRead(s);
    for (int s = 0; s < 1024; s++) begin
      logic [23:0] a;
      a = {4'(s * 3 + int'(inv)), 10'(s), 10'(s * 7 + 3)};
      lookup("R2", a, (s % 3) != 0, s[1] ^ s[4], 16'(s * 4951 + 9),
             16'(s * 313) ^ 16'hA5A5);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] oldE, newE;
    repeat (3) @(negedge clk);
    // R11: state while held in reset
    chk("R11", "rspValid", 32'(rspValid), 32'd0);
    chk("R11", "mapRdValid", 32'(mapRdValid), 32'd0);
    chk("R11", "laneEn", 32'(rspLaneEn), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "rspValid after release", 32'(rspValid), 32'd0);
    chk("R11", "laneEn after release", 32'(rspLaneEn), 32'd0);

    sweep(1'b0);
    sweep(1'b1);

    // R3: valid is a single pulse
    hostRead(17);
    @(negedge clk);
    chk("R3", "valid drops", 32'(mapRdValid), 32'd0);
    // R4: no response without a request
    chk("R4", "idle rspValid", 32'(rspValid), 32'd0);

    // R1: top nibble ignored
    hostWrite(300, 16'h2155);
    lookup("R1", {4'h0, 10'd300, 10'h2A5}, 1'b1, 1'b0, 16'h1234, 16'h5678);
    lookup("R1", {4'hF, 10'd300, 10'h2A5}, 1'b1, 1'b0, 16'h1234, 16'h5678);
    // R2: entry bits 14 and 12 do not alter translation
    hostWrite(301, 16'h5055);
    lookup("R2", {4'h3, 10'd301, 10'h0F0}, 1'b0, 1'b1, 16'h00AB, 16'hC3D4);

    // R8: on-board frame above 255 versus expansion frame above 255
    hostWrite(400, 16'h0F01);
    lookup("R8", {4'h0, 10'd400, 10'h001}, 1'b1, 1'b0, 16'hBEEF, 16'hCAFE);
    chk("R8", "oor raised", 32'(rspOutOfRange), 32'd1);
    hostWrite(401, 16'h2F01);
    lookup("R8", {4'h0, 10'd401, 10'h001}, 1'b1, 1'b0, 16'hBEEF, 16'hCAFE);
    chk("R8", "oor with expansion", 32'(rspOutOfRange), 32'd0);

    // R6: byte lane inversion under the order flag
    hostWrite(500, 16'h8022);
    lookup("R6", {4'h0, 10'd500, 10'h010}, 1'b0, 1'b0, 16'h0077, 16'h1188);
    chk("R6", "inverted lane", 32'(rspLaneEn), 32'b10);
    hostWrite(501, 16'h0022);
    lookup("R6", {4'h0, 10'd501, 10'h010}, 1'b0, 1'b0, 16'h0077, 16'h1188);
    chk("R6", "plain lane", 32'(rspLaneEn), 32'b01);

    // R9: aliasing of the top slot and another slot onto frame 0
    hostWrite(1023, 16'h8000);
    hostWrite(5, 16'h8000);
    lookup("R9", 24'hFFFFF4, 1'b1, 1'b0, 16'h0102, 16'h0304);
    chk("R9", "top alias phys", 32'(rspPhysAddr), 32'h003F4);
    lookup("R9", {4'h0, 10'd5, 10'h3F4}, 1'b1, 1'b0, 16'h0102, 16'h0304);
    chk("R9", "low alias phys", 32'(rspPhysAddr), 32'h003F4);

    // R10: write, lookup and readback of one slot in the same cycle
    oldE = 16'h0123;
    newE = 16'hA2C7;
    hostWrite(7, oldE);
    mapWrEn = 1'b1; mapRdEn = 1'b1; mapSlot = 10'd7; mapWrData = newE;
    reqValid = 1'b1; reqAddr = {4'h0, 10'd7, 10'h155}; reqWide = 1'b1;
    reqHiByte = 1'b0; reqWrData = 16'h3C5A;
    @(negedge clk);
    mapWrEn = 1'b0; mapRdEn = 1'b0; reqValid = 1'b0;
    memRdData = 16'h9F10;
    #1;
    chk("R10", "readback old", 32'(mapRdData), 32'(oldE));
    expectRsp("R10", oldE, {4'h0, 10'd7, 10'h155}, 1'b1, 1'b0, 16'h3C5A, 16'h9F10);
    model[7] = newE;
    @(negedge clk);
    lookup("R10", {4'h0, 10'd7, 10'h155}, 1'b1, 1'b0, 16'h3C5A, 16'h9F10);
    hostRead(7);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule